// File: doc/BRIEF.md
# Byte-Multiplexed Converter Read Controller

This block runs on the host side of a 12-bit successive-approximation converter that shares a parallel bus with it. The converter starts a new conversion whenever it sees a read with its byte-select held low. The block drives the active-low chip select and read strobe and the byte-select line, and it watches the converter's BUSY status. Each result is returned as a zero-extended 16-bit word with a single-cycle valid pulse.

Two bus widths are supported and chosen by `byte_mode`. On the wide bus one read with byte-select low returns all twelve bits and also starts the next conversion. On the 8-bit bus the block first reads with byte-select high, which starts nothing. On that read the lowest four lines carry bits 11..8. It then reads with byte-select low to get bits 7..0 from the eight lower lines, and that second read starts the next conversion.

After reset the block issues a throw-away read with byte-select low to start the first conversion. Before every result read it waits for BUSY to go low and then high again. If either wait lasts longer than a set limit, it raises a sticky error and starts over with another throw-away read.

Top module: `adc_byte_reader`

## Requirements
- R1: While `rst_n` is low, `cs_n` and `rd_n` are high, and `result_valid` and `timeout_err` are low.
- R2: The first read after reset has `hben` low. Its data never produces a `result_valid`, so the first result reported is the value of the first conversion.
- R3: `rd_n` is low only while `cs_n` is low. `cs_n` goes low at least one cycle before `rd_n` falls, and `hben` holds the same value from that cycle until the strobe ends.
- R4: Each read holds `rd_n` low for exactly `STROBE_CYCLES` consecutive cycles, and the data is sampled in the last of them.
- R5: With `byte_mode` at 0, each result comes from one read with `hben` low and equals `bus_i[11:0]` (bit 11 is the most significant bit).
- R6: With `byte_mode` at 1, each result comes from a read with `hben` high followed by a read with `hben` low. Bits 11..8 come from `bus_i[3:0]` of the first read, bits 7..0 come from `bus_i[7:0]` of the second, and `bus_i[11:8]` is not used.
- R7: Every read with `hben` low starts exactly one conversion. A new result read begins only after `busy_i` has been seen low and then high.
- R8: `result_valid` is high for one cycle per result, and `result[15:12]` is 0 at that time.
- R9: If `busy_i` does not fall, or does not rise again, within `TIMEOUT_CYCLES` cycles, `timeout_err` goes high and stays high until reset. The block then issues a new read with `hben` low whose data is discarded.
- R10: `byte_mode` is sampled when a result sequence begins, so the bus width can change between results without corrupting them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| byte_mode | input | 1 | 1 selects two 8-bit reads per result, 0 selects one 12-bit read |
| busy_i | input | 1 | Converter status: low while a conversion is in progress |
| bus_i | input | 12 | Converter data lines; only [7:0] are used in byte mode |
| cs_n | output | 1 | Active-low chip select |
| rd_n | output | 1 | Active-low read strobe |
| hben | output | 1 | Byte select: high requests the upper nibble and starts no conversion |
| result | output | 16 | Last result, zero-extended |
| result_valid | output | 1 | One-cycle pulse when `result` is updated |
| timeout_err | output | 1 | Sticky flag set when a BUSY wait exceeds its limit |

## Verification
A wrong read phase, such as a byte-select level reversed or a missing high-nibble read, shows up as a conversion started early or a result with swapped nibbles. These errors appear at the first `result_valid` after the fault, within one conversion time. A skipped throw-away read, or a BUSY wait that ends too early, shifts the result stream against the sequence of conversions, and the comparison against the queue of expected values catches this on the next result. A stuck wait shows up as `timeout_err` no later than `TIMEOUT_CYCLES` plus one conversion after the converter stops answering.

// File: rtl/adc_byte_reader.sv
module adc_byte_reader #(
  parameter int STROBE_CYCLES  = 2,
  parameter int TIMEOUT_CYCLES = 1000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        byte_mode,
  input  logic        busy_i,
  input  logic [11:0] bus_i,
  output logic        cs_n,
  output logic        rd_n,
  output logic        hben,
  output logic [15:0] result,
  output logic        result_valid,
  output logic        timeout_err
);
  localparam int CMAX = (TIMEOUT_CYCLES > STROBE_CYCLES) ? TIMEOUT_CYCLES : STROBE_CYCLES;
  localparam int CW   = $clog2(CMAX + 1);

  typedef enum logic [2:0] {S_IDLE, S_SETUP, S_STRB, S_GAP, S_WLO, S_WHI} st_t;

  st_t          st;
  logic [CW-1:0] cnt;
  logic          hb_q, dummy_q, mode_q;
  logic [3:0]    nib_q;

  assign cs_n = !(st == S_SETUP || st == S_STRB);
  assign rd_n = (st != S_STRB);
  assign hben = hb_q;

  wire strobe_end = (st == S_STRB) && (cnt == CW'(STROBE_CYCLES - 1));
  wire wait_out   = (st == S_WLO || st == S_WHI) && (cnt == CW'(TIMEOUT_CYCLES - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st           <= S_IDLE;
      cnt          <= '0;
      hb_q         <= 1'b0;
      dummy_q      <= 1'b1;
      mode_q       <= 1'b0;
      nib_q        <= '0;
      result       <= '0;
      result_valid <= 1'b0;
      timeout_err  <= 1'b0;
    end else begin
      result_valid <= 1'b0;
      case (st)
        S_IDLE: begin
          hb_q <= 1'b0;
          st   <= S_SETUP;
        end
        S_SETUP: begin
          cnt <= '0;
          st  <= S_STRB;
        end
        S_STRB: begin
          cnt <= cnt + 1'b1;
          if (strobe_end) begin
            st <= S_GAP;
            if (hb_q) nib_q <= bus_i[3:0];
            else begin
              dummy_q <= 1'b0;
              if (!dummy_q) begin
                result       <= mode_q ? {4'h0, nib_q, bus_i[7:0]} : {4'h0, bus_i};
                result_valid <= 1'b1;
              end
            end
          end
        end
        S_GAP: begin
          cnt <= '0;
          if (hb_q) begin
            hb_q <= 1'b0;
            st   <= S_SETUP;
          end else st <= S_WLO;
        end
        S_WLO, S_WHI: begin
          cnt <= cnt + 1'b1;
          if (wait_out) begin
            timeout_err <= 1'b1;
            dummy_q     <= 1'b1;
            st          <= S_IDLE;
          end else if (st == S_WLO && !busy_i) begin
            cnt <= '0;
            st  <= S_WHI;
          end else if (st == S_WHI && busy_i) begin
            mode_q <= byte_mode;
            hb_q   <= byte_mode;
            st     <= S_SETUP;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/adc_byte_reader_chk.sv
module adc_byte_reader_chk #(
  parameter int STROBE_CYCLES = 2
) (
  input logic        clk,
  input logic        rst_n,
  input logic        cs_n,
  input logic        rd_n,
  input logic        hben,
  input logic [15:0] result,
  input logic        result_valid,
  input logic        timeout_err
);
  logic [15:0] low_len;

  always_ff @(posedge clk) begin
    if (!rst_n) low_len <= '0;
    else if (!rd_n) low_len <= low_len + 1'b1;
    else low_len <= '0;
  end

  a_r3_cs_covers_rd: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> !cs_n);
  a_r3_setup_before_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rd_n) |-> ($past(!cs_n) && $stable(hben)));
  a_r3_hben_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && $past(!cs_n)) |-> $stable(hben));
  a_r4_strobe_len: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_n) |-> (low_len == 16'(STROBE_CYCLES)));
  a_r8_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid |=> !result_valid);
  a_r8_zero_ext: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid |-> (result[15:12] == 4'h0));
  a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_err |=> timeout_err);
endmodule

bind adc_byte_reader adc_byte_reader_chk #(.STROBE_CYCLES(STROBE_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .hben(hben),
  .result(result), .result_valid(result_valid), .timeout_err(timeout_err)
);

// File: tb/adc_byte_reader_test.sv
module adc_byte_reader_test;
  localparam int STROBE = 3;
  localparam int TMO    = 60;
  localparam int CONV   = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic byte_mode = 1'b0;
  logic busy_i;
  logic [11:0] bus_i;
  logic cs_n, rd_n, hben, result_valid, timeout_err;
  logic [15:0] result;

  always #4 clk = ~clk;

  adc_byte_reader #(.STROBE_CYCLES(STROBE), .TIMEOUT_CYCLES(TMO)) uut (
    .clk(clk), .rst_n(rst_n), .byte_mode(byte_mode), .busy_i(busy_i), .bus_i(bus_i),
    .cs_n(cs_n), .rd_n(rd_n), .hben(hben), .result(result),
    .result_valid(result_valid), .timeout_err(timeout_err));

  int checks = 0, fails = 0, nres = 0, starts = 0, lo_reads = 0, cyc = 0;
  logic [11:0] exp_q[$];

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // converter model
  logic [11:0] out_reg;
  logic        prev_rd_n, stuck;
  int          ccnt, conv_k;

  function automatic logic [11:0] conv_val(input int k);
    case (k)
      0: return 12'h000;
      1: return 12'hFFF;
      2: return 12'h8F0;
      3: return 12'h0A5;
      4: return 12'hF0F;
      default: return 12'((k * 32'h9E3 + 32'h1B) & 32'hFFF);
    endcase
  endfunction

  always_comb begin
    if (!cs_n && !rd_n) bus_i = hben ? {out_reg[11:8], 4'h0, out_reg[11:8]} : out_reg;
    else bus_i = 12'hFFF;
  end

  initial stuck = 1'b0;

  always @(posedge clk) begin
    if (!rst_n) begin
      out_reg <= 12'h5A5; busy_i <= 1'b1; prev_rd_n <= 1'b1; ccnt <= 0; conv_k <= 0;
    end else begin
      prev_rd_n <= rd_n;
      if (!cs_n && !rd_n && !hben && prev_rd_n && busy_i && !stuck) begin
        busy_i <= 1'b0; ccnt <= CONV; starts <= starts + 1;
      end else if (!busy_i) begin
        if (ccnt == 1) begin
          busy_i <= 1'b1;
          out_reg <= conv_val(conv_k);
          exp_q.push_back(conv_val(conv_k));
          conv_k <= conv_k + 1;
        end
        ccnt <= ccnt - 1;
      end
    end
  end

  // monitor / scoreboard
  int   low_len = 0;
  bit   hi_seen = 0, prev_valid = 0, prev_cs_n = 1, prev_hben = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (!rd_n) begin
        if (low_len == 0) begin
          check(!prev_cs_n, "R3 cs_n low before strobe", prev_cs_n, 0);
          check(hben == prev_hben, "R3 hben settled", hben, prev_hben);
          if (hben) hi_seen = 1; else lo_reads++;
        end
        low_len++;
      end else if (low_len != 0) begin
        check(low_len == STROBE, "R4 strobe length", low_len, STROBE);
        low_len = 0;
      end
      if (result_valid) begin
        logic [11:0] e;
        check(!prev_valid, "R8 single-cycle valid", prev_valid, 0);
        check(result[15:12] == 0, "R8 zero extension", result[15:12], 0);
        if (exp_q.size() == 0) check(0, "R2 result before any conversion", result, 0);
        else begin
          e = exp_q.pop_front();
          check(result == {4'h0, e}, byte_mode ? "R6 byte-mode result" : "R5 wide result", result, {4'h0, e});
        end
        check(hi_seen == byte_mode, "R10 read pattern follows mode", hi_seen, byte_mode);
        hi_seen = 0;
        nres++;
      end
    end
    prev_valid = result_valid;
    prev_cs_n  = cs_n;
    prev_hben  = hben;
  end

  task automatic wait_results(input int n);
    int target = nres + n;
    while (nres < target) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      check(0, "watchdog", cyc, 150000);
      finish_run();
    end
  end

  initial begin
    int t;
    repeat (4) @(negedge clk);
    check(cs_n && rd_n, "R1 bus idle in reset", {cs_n, rd_n}, 2'b11);
    check(!result_valid && !timeout_err, "R1 flags low in reset", {result_valid, timeout_err}, 0);
    rst_n = 1'b1;
    t = 0;
    while (rd_n && t < 20) begin @(negedge clk); t++; end
    check(!rd_n && !hben, "R2 first read has hben low", {rd_n, hben}, 0);
    check(nres == 0, "R2 first read discarded", nres, 0);

    wait_results(6);
    check(lo_reads == starts, "R7 each hben-low read starts a conversion", starts, lo_reads);
    byte_mode = 1'b1;
    wait_results(6);
    check(lo_reads == starts, "R7 byte-mode reads start one conversion each", starts, lo_reads);
    byte_mode = 1'b0;
    wait_results(3);

    stuck = 1'b1;
    t = 0;
    while (!timeout_err && t < 2 * TMO + CONV + 40) begin @(negedge clk); t++; end
    check(timeout_err, "R9 timeout flagged", timeout_err, 1);
    stuck = 1'b0;
    t = nres;
    wait_results(3);
    check(timeout_err, "R9 error stays set", timeout_err, 1);
    check(nres == t + 3, "R9 recovery after dummy read", nres, t + 3);
    check(exp_q.size() == 0, "R7 no unread conversions", exp_q.size(), 0);
    finish_run();
  end
endmodule